// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor load/store port and a slower line-wide memory. It holds 8 KB as 128 sets of two 32-byte lines. Each line has its own tag, valid flag and modified flag. The processor issues one 32-bit word access at a time. Both ways of the addressed set are compared in parallel, and a hit finishes in one cycle.

On a miss the processor is stalled. If the chosen victim line holds modified data, that line is first sent to memory. The missing line is then fetched and installed clean, and the access is replayed against the freshly installed line. Stores that miss allocate the line before the word is written. Within a set, a single recency bit picks the victim. An empty way is always used before a valid line is displaced.

Top module: `cache_2way_wb`

## Requirements
- R1: The address splits into word select [4:2], set index [11:5] and tag [33:12]. Two lines with the same index and different tags can both be resident, and at most one way ever matches.
- R2: A read hit raises cpu_done in the cycle after acceptance, with the addressed word on cpu_rdata, and makes no memory request.
- R3: A write hit updates the addressed word and marks the line modified. It completes in the cycle after acceptance and makes no memory request.
- R4: A miss into a set that has an empty way fills that way and writes nothing back.
- R5: When both ways are valid, the victim is the way used less recently. Every hit and every fill makes the touched way the most recent.
- R6: A modified victim is written to memory before the refill, as a write request carrying the whole line at line address {victim tag, index}. A clean victim is overwritten with no write-back.
- R7: A write miss fetches the line, installs it valid and clean, and then performs the write, which leaves the line modified.
- R8: From the cycle after a miss is accepted until the access completes, cpu_ready is low. The access ends with a single cpu_done pulse, and requests are accepted only while cpu_ready is high.
- R9: mem_req stays high with stable mem_we and mem_laddr until a one-cycle mem_ack. On a read, the acknowledged mem_rdata holds word j of the line at bits [32j+31:32j].
- R10: A synchronous active-high reset invalidates every line and clears the recency state. After reset, cpu_ready is 1, cpu_done is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken while cpu_ready is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 34 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_done | output | 1 | One-cycle pulse when an access completes |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| mem_req | output | 1 | Line transfer request to memory |
| mem_we | output | 1 | 1 = write-back, 0 = line fetch |
| mem_laddr | output | 29 | Line address (byte address bits [33:5]) |
| mem_wdata | output | 256 | Line being written back |
| mem_ack | input | 1 | One-cycle completion of the current transfer |
| mem_rdata | input | 256 | Fetched line, valid with mem_ack |

## Verification
The assertions assume the memory raises mem_ack only while mem_req is high, and only for one cycle per transfer. They also assume mem_rdata is valid in that acknowledged cycle. The processor side is assumed to hold no request outside cpu_ready, and to wait for cpu_done before its next access. The stimulus meets both assumptions. It issues one single-cycle request at a time and waits for the completion pulse. The memory model acknowledges each transfer once, after a fixed delay, and only while a request is pending.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_FILL   = 2'd2,
    ST_REPLAY = 2'd3
  } cst_e;
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
  parameter int SETS  = 128,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic             dirty_way,
  output logic [1:0]       hit_vec,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag
);
  import cache2w_pkg::*;

  logic [TAG_W-1:0] way_tag [WAYS];
  logic [SETS-1:0]  valid_w [WAYS];
  logic [SETS-1:0]  dirty_w [WAYS];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_ram [SETS];
    logic [SETS-1:0]  valid_r;
    logic [SETS-1:0]  dirty_r;
    logic             this_fill;
    logic             this_dirty;

    assign this_fill  = fill_en && (fill_way == 1'(w));
    assign this_dirty = dirty_en && (dirty_way == 1'(w));

    always_ff @(posedge clk) begin
      if (this_fill) tag_ram[idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_r <= '0;
        dirty_r <= '0;
      end else if (this_fill) begin
        valid_r[idx] <= 1'b1;
        dirty_r[idx] <= 1'b0;
      end else if (this_dirty) begin
        dirty_r[idx] <= 1'b1;
      end
    end

    assign way_tag[w] = tag_ram[idx];
    assign valid_w[w] = valid_r;
    assign dirty_w[w] = dirty_r;
    assign hit_vec[w] = valid_r[idx] && (tag_ram[idx] == tag);
  end

  // recency bit names the way to evict next
  always_ff @(posedge clk) begin
    if (rst)           lru_q      <= '0;
    else if (fill_en)  lru_q[idx] <= ~fill_way;
    else if (touch_en) lru_q[idx] <= ~touch_way;
  end

  always_comb begin
    if (!valid_w[0][idx])      vic_way = 1'b0;
    else if (!valid_w[1][idx]) vic_way = 1'b1;
    else                       vic_way = lru_q[idx];
  end

  assign vic_dirty = dirty_w[vic_way][idx];
  assign vic_tag   = way_tag[vic_way];

  // R1
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R7
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_w[$past(fill_way)][$past(idx)] &&
                 !dirty_w[$past(fill_way)][$past(idx)]));

  // R3
  dirty_mark_chk: assert property (@(posedge clk) disable iff (rst)
    dirty_en |=> dirty_w[$past(dirty_way)][$past(idx)]);
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic                           clk,
  input  logic [IDX_W-1:0]               idx,
  input  logic                           fill_en,
  input  logic                           fill_way,
  input  logic [LINE_W-1:0]              fill_line,
  input  logic                           word_we,
  input  logic                           word_way,
  input  logic [WSEL_W-1:0]              word_sel,
  input  logic [WORD_W-1:0]              word_data,
  output logic [cache2w_pkg::WAYS*LINE_W-1:0] rd_bus
);
  import cache2w_pkg::*;

  // one narrow RAM per way and word column so a single word can be written
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar j = 0; j < WORDS; j++) begin : g_col
      logic [WORD_W-1:0] ram [SETS];
      logic [WORD_W-1:0] q_r;
      logic              we_fill;
      logic              we_word;
      logic [WORD_W-1:0] wd;

      assign we_fill = fill_en && (fill_way == 1'(w));
      assign we_word = word_we && (word_way == 1'(w)) && (word_sel == WSEL_W'(j));
      assign wd      = we_fill ? fill_line[j*WORD_W +: WORD_W] : word_data;

      always_ff @(posedge clk) begin
        if (we_fill || we_word) ram[idx] <= wd;
        q_r <= ram[idx];
      end

      assign rd_bus[(w*WORDS + j)*WORD_W +: WORD_W] = q_r;
    end
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
  parameter int ADDR_W = 34,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 3,
  parameter int WORD_W = 32,
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int BSEL_W  = OFF_W - WSEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic [1:0]         hit_vec,
  input  logic               vic_way,
  input  logic               vic_dirty,
  input  logic [TAG_W-1:0]   vic_tag,
  input  logic               mem_ack,
  output logic [IDX_W-1:0]   acc_idx,
  output logic [TAG_W-1:0]   acc_tag,
  output logic [WSEL_W-1:0]  acc_wsel,
  output logic               word_we,
  output logic               word_way,
  output logic [WORD_W-1:0]  word_data,
  output logic               fill_en,
  output logic               fill_way,
  output logic [TAG_W-1:0]   fill_tag,
  output logic               touch_en,
  output logic               touch_way,
  output logic               dirty_en,
  output logic               dirty_way,
  output logic               hway_q,
  output logic [WSEL_W-1:0]  wsel_q,
  output logic               victim_q,
  output logic               cpu_ready,
  output logic               cpu_done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_laddr
);
  import cache2w_pkg::*;

  cst_e              st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              done_q;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic              look;
  logic              hit;
  logic              any_hit;
  logic              unused_lo;

  assign cur_addr  = (st_q == ST_IDLE) ? cpu_addr : addr_q;
  assign cur_we    = (st_q == ST_IDLE) ? cpu_we : we_q;
  assign word_data = (st_q == ST_IDLE) ? cpu_wdata : wdata_q;
  assign unused_lo = ^cur_addr[BSEL_W-1:0];

  assign acc_tag  = cur_addr[ADDR_W-1 -: TAG_W];
  assign acc_idx  = cur_addr[OFF_W +: IDX_W];
  assign acc_wsel = cur_addr[BSEL_W +: WSEL_W];

  assign any_hit = |hit_vec;
  assign look    = ((st_q == ST_IDLE) && cpu_req) || (st_q == ST_REPLAY);
  assign hit     = look && any_hit;

  assign word_we   = hit && cur_we;
  assign word_way  = hit_vec[1];
  assign touch_en  = hit;
  assign touch_way = hit_vec[1];
  assign dirty_en  = hit && cur_we;
  assign dirty_way = hit_vec[1];

  assign fill_en  = (st_q == ST_FILL) && mem_ack;
  assign fill_way = victim_q;
  assign fill_tag = addr_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= hit;
      case (st_q)
        ST_IDLE:  if (cpu_req && !any_hit) st_q <= vic_dirty ? ST_WBACK : ST_FILL;
        ST_WBACK: if (mem_ack) st_q <= ST_FILL;
        ST_FILL:  if (mem_ack) st_q <= ST_REPLAY;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((st_q == ST_IDLE) && cpu_req) begin
      addr_q   <= cpu_addr;
      we_q     <= cpu_we;
      wdata_q  <= cpu_wdata;
      victim_q <= vic_way;
      vtag_q   <= vic_tag;
    end
    if (hit) begin
      hway_q <= hit_vec[1];
      wsel_q <= acc_wsel;
    end
  end

  assign cpu_ready = (st_q == ST_IDLE);
  assign cpu_done  = done_q;
  assign mem_req   = (st_q == ST_WBACK) || (st_q == ST_FILL);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_laddr = (st_q == ST_WBACK) ? {vtag_q, addr_q[OFF_W +: IDX_W]}
                                        : addr_q[ADDR_W-1:OFF_W];

  // R6
  wb_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WBACK) |-> vic_dirty);

  // R7
  replay_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REPLAY) |-> any_hit);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_laddr)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_ready);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $fell(rst) |-> (cpu_ready && !cpu_done && !mem_req));
endmodule

// File: rtl/cache_2way_wb.sv
module cache_2way_wb #(
  parameter int ADDR_W     = 34,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int SETS       = 128,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int WORD_W  = 8 * WORD_BYTES,
  localparam int WORDS   = LINE_BYTES / WORD_BYTES,
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int LINE_W  = 8 * LINE_BYTES,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic               cpu_done,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_laddr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [LINE_W-1:0]  mem_rdata
);
  import cache2w_pkg::*;

  logic [IDX_W-1:0]       acc_idx;
  logic [TAG_W-1:0]       acc_tag;
  logic [WSEL_W-1:0]      acc_wsel;
  logic                   word_we, word_way;
  logic [WORD_W-1:0]      word_data;
  logic                   fill_en, fill_way;
  logic [TAG_W-1:0]       fill_tag;
  logic                   touch_en, touch_way;
  logic                   dirty_en, dirty_way;
  logic [1:0]             hit_vec;
  logic                   vic_way, vic_dirty;
  logic [TAG_W-1:0]       vic_tag;
  logic                   hway_q, victim_q;
  logic [WSEL_W-1:0]      wsel_q;
  logic [WAYS*LINE_W-1:0] rd_bus;

  cache2w_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .WSEL_W(WSEL_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .hit_vec(hit_vec), .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .mem_ack(mem_ack),
    .acc_idx(acc_idx), .acc_tag(acc_tag), .acc_wsel(acc_wsel),
    .word_we(word_we), .word_way(word_way), .word_data(word_data),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .touch_en(touch_en), .touch_way(touch_way),
    .dirty_en(dirty_en), .dirty_way(dirty_way),
    .hway_q(hway_q), .wsel_q(wsel_q), .victim_q(victim_q),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_laddr(mem_laddr)
  );

  cache2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(acc_idx), .tag(acc_tag),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .touch_en(touch_en), .touch_way(touch_way),
    .dirty_en(dirty_en), .dirty_way(dirty_way),
    .hit_vec(hit_vec), .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag)
  );

  cache2w_data #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .idx(acc_idx),
    .fill_en(fill_en), .fill_way(fill_way), .fill_line(mem_rdata),
    .word_we(word_we), .word_way(word_way), .word_sel(acc_wsel), .word_data(word_data),
    .rd_bus(rd_bus)
  );

  // way-select multiplexer after the registered RAM outputs
  assign cpu_rdata = rd_bus[(int'(hway_q)*WORDS + int'(wsel_q))*WORD_W +: WORD_W];
  assign mem_wdata = rd_bus[int'(victim_q)*LINE_W +: LINE_W];
endmodule

// File: tb/test_cache_2way_wb.sv
`timescale 1ns/1ps
module test_cache_2way_wb;
  localparam int MEM_LAT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0;
  logic         cpu_we = 1'b0;
  logic [33:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_ready, cpu_done;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [28:0]  mem_laddr;
  logic [255:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [255:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int n_fill = 0;
  int n_wb = 0;
  logic [255:0] mline [longint];
  logic [31:0]  shadow [longint];

  always #4 clk = ~clk;

  cache_2way_wb i_cache_2way_wb (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_laddr(mem_laddr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] dflt_word(input logic [31:0] wa);
    return wa * 32'h9E3779B1 + 32'h00001234;
  endfunction

  function automatic logic [255:0] dflt_line(input logic [28:0] la);
    logic [255:0] l;
    for (int j = 0; j < 8; j++) l[j*32 +: 32] = dflt_word({la, 3'(j)});
    return l;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] wa);
    if (shadow.exists(longint'(wa))) return shadow[longint'(wa)];
    if (mline.exists(longint'(wa[31:3]))) return mline[longint'(wa[31:3])][wa[2:0]*32 +: 32];
    return dflt_word(wa);
  endfunction

  // line memory: answers one pending transfer after MEM_LAT cycles
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 1'b0;
        lat = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        lat++;
        if (lat == MEM_LAT) begin
          lat = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mline[longint'(mem_laddr)] = mem_wdata;
            n_wb++;
          end else begin
            mem_rdata = mline.exists(longint'(mem_laddr)) ? mline[longint'(mem_laddr)]
                                                         : dflt_line(mem_laddr);
            n_fill++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, expv);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [21:0] tg;
    logic [6:0]  ix;
    logic [2:0]  wd;
    logic [31:0] dat;
    logic        fl;
    logic        wb;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 22'd1, 7'd5,   3'd0, 32'h0,        1'b1, 1'b0},  // R4 R9 first fill, empty way
    '{1'b0, 22'd1, 7'd5,   3'd3, 32'h0,        1'b0, 1'b0},  // R2 read hit
    '{1'b1, 22'd2, 7'd5,   3'd1, 32'hCAFE0001, 1'b1, 1'b0},  // R7 R4 write miss into empty way
    '{1'b0, 22'd2, 7'd5,   3'd1, 32'h0,        1'b0, 1'b0},  // R1 second tag resident
    '{1'b0, 22'd1, 7'd5,   3'd2, 32'h0,        1'b0, 1'b0},  // R1 R5 hit makes tag1 recent
    '{1'b0, 22'd3, 7'd5,   3'd0, 32'h0,        1'b1, 1'b1},  // R5 R6 dirty LRU victim
    '{1'b0, 22'd2, 7'd5,   3'd1, 32'h0,        1'b1, 1'b0},  // R6 clean victim, data via memory
    '{1'b1, 22'd0, 7'd9,   3'd7, 32'hB0B0B0B0, 1'b1, 1'b0},  // R7 write miss
    '{1'b1, 22'd0, 7'd9,   3'd7, 32'hC0C0C0C0, 1'b0, 1'b0},  // R3 write hit
    '{1'b0, 22'd0, 7'd9,   3'd7, 32'h0,        1'b0, 1'b0},  // R3 read back
    '{1'b0, 22'd4, 7'd9,   3'd0, 32'h0,        1'b1, 1'b0},  // R4 second way
    '{1'b0, 22'd5, 7'd9,   3'd0, 32'h0,        1'b1, 1'b1},  // R5 R6 evict dirty tag0
    '{1'b0, 22'd0, 7'd9,   3'd7, 32'h0,        1'b1, 1'b0},  // R6 written-back word returns
    '{1'b1, 22'd7, 7'd127, 3'd0, 32'hD00DD00D, 1'b1, 1'b0},  // R1 top index
    '{1'b0, 22'd7, 7'd0,   3'd0, 32'h0,        1'b1, 1'b0},  // R1 index zero separate set
    '{1'b0, 22'd7, 7'd127, 3'd0, 32'h0,        1'b0, 1'b0}   // R1 top index still resident
  };

  task automatic do_acc(input vec_t v);
    logic [31:0] wa;
    logic [31:0] expv;
    int cyc;
    wa = {v.tg, v.ix, v.wd};
    expv = expect_word(wa);
    n_fill = 0;
    n_wb = 0;
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = v.we;
    cpu_addr = {v.tg, v.ix, v.wd, 2'b00};
    cpu_wdata = v.dat;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    if (v.fl) chk(!cpu_ready && !cpu_done, "R8 stall", {30'd0, cpu_ready, cpu_done}, 32'd0);
    while (!cpu_done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    if (!v.fl) chk(cyc == 1, v.we ? "R3 hit latency" : "R2 hit latency", cyc, 1);
    chk(n_fill == int'(v.fl), "R4/R5 fill count", n_fill, {31'd0, v.fl});
    chk(n_wb == int'(v.wb), "R6 write-back count", n_wb, {31'd0, v.wb});
    if (v.we) shadow[longint'(wa)] = v.dat;
    else chk(cpu_rdata == expv, "R9 read data", cpu_rdata, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 idle after reset
    chk(cpu_ready && !cpu_done && !mem_req, "R10 reset outputs",
        {29'd0, cpu_ready, cpu_done, mem_req}, 32'h4);

    for (int k = 0; k < 16; k++) do_acc(VEC[k]);

    // R10 reset drops every line, including the unwritten modified one
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    shadow.delete();
    @(negedge clk);
    chk(cpu_ready && !cpu_done && !mem_req, "R10 reset outputs again",
        {29'd0, cpu_ready, cpu_done, mem_req}, 32'h4);
    do_acc('{1'b0, 22'd7, 7'd127, 3'd0, 32'h0, 1'b1, 1'b0});  // R10 refetch, old value
    do_acc('{1'b0, 22'd8, 7'd127, 3'd0, 32'h0, 1'b1, 1'b0});  // R4 second way
    do_acc('{1'b0, 22'd9, 7'd127, 3'd0, 32'h0, 1'b1, 1'b0});  // R5 clean victim

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule